// File: doc/BRIEF.md
# Condition Code Evaluator

This block decides whether a conditionally executed instruction may run. It keeps the four arithmetic status flags (negative, zero, carry, overflow) in a small register store and compares them against a 4-bit condition selector. The result is a single pass signal. Several selectors test one flag in either sense. Others combine flags to give unsigned ordering (carry together with zero) or signed ordering (negative compared with overflow, plus zero).

The flag store is written on a rising clock edge while the write strobe is high. A 4-bit lane mask chooses which flags take new values, and the flags left out of the mask keep their old values. The pass output is combinational from the stored flags and the selector, so a selector change is seen in the same cycle. A flag write is seen in the cycle after its edge.

Top module: `cond_eval`

## Requirements
- R1: After reset all four stored flags are 0, so the pass output for selector 4'b0001 (not-equal) is 1 and for selector 4'b0000 (equal) is 0.
- R2: Selector 0000 passes when Z=1 and selector 0001 passes when Z=0.
- R3: Selector 0010 passes when C=1 and selector 0011 passes when C=0.
- R4: Selectors 0100 and 0101 pass when N=1 and N=0 respectively. Selectors 0110 and 0111 pass when V=1 and V=0 respectively.
- R5: Selector 1000 passes only when C=1 and Z=0. Selector 1001 passes when C=0 or Z=1.
- R6: Selector 1010 passes when N equals V. Selector 1011 passes when N differs from V.
- R7: Selector 1100 passes when Z=0 and N equals V. Selector 1101 passes when Z=1 or N differs from V.
- R8: Selector 1110 always passes and selector 1111 never passes.
- R9: On a rising edge with wr_en=1, each flag whose mask bit is set takes its new value. The mask and value bits are ordered {N,Z,C,V}, with N at bit 3 and V at bit 0. Flags whose mask bit is clear keep their value.
- R10: With wr_en=0 the stored flags do not change, whatever the mask and value inputs are.
- R11: The pass output depends only on the current stored flags and the selector, with no cycle of delay from the selector. A flag write changes the pass output from the cycle after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Flag write strobe |
| wr_mask | input | 4 | Per-flag write lanes {N,Z,C,V} |
| wr_flags | input | 4 | New flag values {N,Z,C,V} |
| cond_sel | input | 4 | Condition selector |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |
| pass_o | output | 1 | Condition holds |

## Verification
A flag register that is wrong shows up in flags_o in the cycle after the faulty write. It also shows up in pass_o for any selector that depends on that flag. The bench sweeps all sixteen selectors over all sixteen flag states, so a wrong term in any condition shows up within one sweep. Lane writes with mixed masks catch a mask bit wired to the wrong flag. Writes made with the strobe low catch a store that ignores the strobe.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;
    localparam int FLAG_W = 4;
    localparam int SEL_W  = 4;
    localparam int IDX_N = 3;
    localparam int IDX_Z = 2;
    localparam int IDX_C = 1;
    localparam int IDX_V = 0;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_EQ = 4'd0,  SEL_NE = 4'd1,  SEL_CS = 4'd2,  SEL_CC = 4'd3,
        SEL_MI = 4'd4,  SEL_PL = 4'd5,  SEL_VS = 4'd6,  SEL_VC = 4'd7,
        SEL_HI = 4'd8,  SEL_LS = 4'd9,  SEL_GE = 4'd10, SEL_LT = 4'd11,
        SEL_GT = 4'd12, SEL_LE = 4'd13, SEL_AL = 4'd14, SEL_NV = 4'd15
    } cond_sel_t;
endpackage

// File: rtl/cond_flag_store.sv
module cond_flag_store
    import cond_eval_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] wr_mask,
    input  logic [FLAG_W-1:0] wr_flags,
    output flags_t            flags_q
);
    typedef struct packed {
        flags_t flags;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            for (int i = 0; i < FLAG_W; i++) begin
                if (wr_mask[i]) begin
                    state_d.flags[i] = wr_flags[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flags_q = state_q.flags;
endmodule

// File: rtl/cond_decode.sv
module cond_decode
    import cond_eval_pkg::*;
(
    input  flags_t           flags,
    input  logic [SEL_W-1:0] sel,
    output logic             pass
);
    logic base_d;
    logic nv_same;

    always_comb begin
        nv_same = (flags.n == flags.v);
        // Pairs share a base test; the low selector bit inverts it.
        unique case (sel[SEL_W-1:1])
            3'd0: base_d = flags.z;
            3'd1: base_d = flags.c;
            3'd2: base_d = flags.n;
            3'd3: base_d = flags.v;
            3'd4: base_d = flags.c & ~flags.z;
            3'd5: base_d = nv_same;
            3'd6: base_d = ~flags.z & nv_same;
            default: base_d = 1'b1;
        endcase
        pass = base_d ^ sel[0];
    end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
    import cond_eval_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] wr_mask,
    input  logic [3:0] wr_flags,
    input  logic [3:0] cond_sel,
    output logic [3:0] flags_o,
    output logic       pass_o
);
    flags_t flags_q;

    cond_flag_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_mask  (wr_mask),
        .wr_flags (wr_flags),
        .flags_q  (flags_q)
    );

    cond_decode u_dec (
        .flags (flags_q),
        .sel   (cond_sel),
        .pass  (pass_o)
    );

    assign flags_o = flags_q;
endmodule

// File: rtl/cond_eval_chk.sv
module cond_eval_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [3:0] wr_mask,
    input logic [3:0] wr_flags,
    input logic [3:0] cond_sel,
    input logic [3:0] flags_o,
    input logic       pass_o
);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(flags_o));
    p_lanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> flags_o == (($past(flags_o) & ~$past(wr_mask)) | ($past(wr_flags) & $past(wr_mask))));
    p_always_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cond_sel == 4'b1110 |-> pass_o);
    p_never_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cond_sel == 4'b1111 |-> !pass_o);
    p_eq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cond_sel == 4'b0000 |-> pass_o == flags_o[2]);
    p_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cond_sel == 4'b1000 |-> pass_o == (flags_o[1] && !flags_o[2]));
    p_gt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cond_sel == 4'b1100 |-> pass_o == (!flags_o[2] && (flags_o[3] == flags_o[0])));
endmodule

bind cond_eval cond_eval_chk u_chk (.*);

// File: tb/cond_eval_tb_top.sv
module cond_eval_tb_top;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       wr_en = 0;
    logic [3:0] wr_mask = 0, wr_flags = 0, cond_sel = 0;
    logic [3:0] flags_o;
    logic       pass_o;
    int checks = 0, failures = 0;
    logic [3:0] model_q = 0;
    logic       done = 0;

    always #10 clk = ~clk;

    cond_eval dut_i (.*);

    function automatic logic ref_pass(input logic [3:0] f, input logic [3:0] s);
        logic n, z, c, v;
        {n, z, c, v} = f;
        case (s)
            0: return z;              1: return !z;
            2: return c;              3: return !c;
            4: return n;              5: return !n;
            6: return v;              7: return !v;
            8: return c && !z;        9: return !c || z;
            10: return n == v;        11: return n != v;
            12: return !z && n == v;  13: return z || n != v;
            14: return 1;             default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] s);
        case (s[3:1])
            0: return "R2";
            1: return "R3";
            2, 3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Reference model, updated at each edge and compared mid-cycle.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) model_q <= 0;
        else if (wr_en) model_q <= (model_q & ~wr_mask) | (wr_flags & wr_mask);
    end

    always @(negedge clk) if (rst_n && !done) begin
        check("R9/R10 flags", flags_o, model_q);
        check("R11 pass", pass_o, ref_pass(model_q, cond_sel));
    end

    task automatic wr(input logic e, input logic [3:0] m, input logic [3:0] f);
        @(negedge clk);
        wr_en = e; wr_mask = m; wr_flags = f;
        @(negedge clk);
        wr_en = 0;
    endtask

    initial begin
        #1;
        cond_sel = 4'b0001; #1 check("R1 ne", pass_o, 1);
        cond_sel = 4'b0000; #1 check("R1 eq", pass_o, 0);
        check("R1 flags", flags_o, 0);
        repeat (2) @(negedge clk);
        rst_n = 1;
        for (int f = 0; f < 16; f++) begin
            wr(1, 4'hF, f[3:0]);
            check("R9 full", flags_o, f[3:0]);
            for (int s = 0; s < 16; s++) begin
                cond_sel = s[3:0]; #1;
                check(req_of(s[3:0]), pass_o, ref_pass(f[3:0], s[3:0]));
            end
        end
        wr(1, 4'hF, 4'b0000);
        wr(1, 4'b0100, 4'b1111);
        check("R9 z lane", flags_o, 4'b0100);
        wr(1, 4'b1001, 4'b1011);
        check("R9 n v lanes", flags_o, 4'b1101);
        wr(0, 4'hF, 4'b0010);
        check("R10 no strobe", flags_o, 4'b1101);
        cond_sel = 4'b1000;
        wr(1, 4'b0110, 4'b0010);
        check("R11 hi after write", pass_o, 1);
        check("R5 hi", pass_o, ref_pass(4'b1011, 4'b1000));
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule